// File: doc/BRIEF.md
# Interrupt Source Controller with Reject and Replay

This block keeps the per-source state for a fixed, parameterized set of interrupt inputs and turns their activity into delivery requests for a presentation stage. Each source is built either as a level source, which follows a wire, or as a message source, which reacts to one-cycle event pulses. Its kind is fixed by the `SRC_IS_LEVEL` parameter (bit i set means source i is a level source). A configuration port gives each source a target server, a priority and a saved priority. The priority value with all ones (0xFF at the default width) masks the source.

Each request carries a source number, the server and the priority. The source number is the local index plus the `BASE` parameter. Requests leave one per cycle on a valid/ready handshake. When several sources are queued, the lowest index wins. A choice that has been shown while ready is low is held until it is taken. The presentation side can send back three notifications: a reject for a number it refused, an end-of-interrupt for a number it finished, and a replay command. Reject and end-of-interrupt carry a source number. The replay command starts a walk over all sources in index order, and the walk re-offers the ones that are eligible.

The walk is a two-state machine. State `SC_IDLE` moves to `SC_WALK` on a replay pulse. In `SC_WALK` one source is visited per cycle; on a cycle where the output is valid but not ready, the walk freezes on its current source. After the last source it returns to `SC_IDLE`. Replay pulses that arrive during `SC_WALK` are ignored.

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset no request is valid, every priority and saved priority reads as masked (all ones), and every status bit is clear. The level/message kind of each source is a parameter and is unchanged by reset.
- R2: A request for local source i carries the source number BASE + i.
- R3: A pulse on a masked message source raises no request and sets that source's masked-pending bit. A pulse on an unmasked message source raises a request, valid in the cycle after the pulse, carrying that source's server and priority.
- R4: A configuration write replaces server, priority and saved priority. If the source is a message source that is masked-pending and the new priority unmasks it, masked-pending is cleared and a request is raised. If the source is a level source, the level check of R5 is run.
- R5: A level source records its line in an asserted bit whenever the line changes. The level check raises a request, and sets the sent bit, only when the source is unmasked, asserted and not yet sent. A line held high therefore yields a single request.
- R6: A reject on a message source sets its rejected bit. A reject on a level source clears its sent bit. Neither raises a request by itself.
- R7: An end-of-interrupt clears the sent bit of a level source. It changes nothing on a message source.
- R8: A replay walk visits sources 0 to N-1 in order. A rejected message source has its rejected bit cleared and is re-requested if unmasked. A level source runs the level check of R5.
- R9: While req_valid_o is high and req_ready_i is low, req_valid_o stays high and req_num_o is stable, and the replay walk does not advance. Queued requests leave lowest index first.
- R10: A reject or end-of-interrupt whose number is below BASE or at or above BASE + N has no effect on any source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | NUM_SRC | Level lines; only bits of level sources are used |
| msg_i | input | NUM_SRC | One-cycle event pulses; only bits of message sources are used |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Local index of the source being written |
| cfg_server_i | input | SRV_W | Target server to store |
| cfg_prio_i | input | PRIO_W | Priority to store (all ones masks) |
| cfg_saved_i | input | PRIO_W | Saved priority to store |
| rej_valid_i | input | 1 | Reject notification strobe |
| rej_num_i | input | NUM_W | Source number being rejected |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | NUM_W | Source number being completed |
| replay_i | input | 1 | Start a replay walk |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Presentation side accepts the request |
| req_num_o | output | NUM_W | Source number (BASE + index) |
| req_server_o | output | SRV_W | Target server |
| req_prio_o | output | PRIO_W | Priority |

## Verification
The hardest state to reach is a replay walk that is frozen mid-way. Reaching it needs a source already queued, the output held not-ready, and a second rejected source further along the walk. The bench first lets two message sources deliver and rejects both. It then drops ready and starts a replay. The walk queues the first source and freezes before the second, and the stall is held for several cycles. When ready returns, the scoreboard requires both numbers in index order. A separate stall case raises two level lines in the same cycle and requires the lower index to be held and delivered first.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [0:0] {
        SC_IDLE = 1'b0,
        SC_WALK = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mpend;
        logic queued;
    } src_stat_t;

endpackage

// File: rtl/isc_source_slice.sv
module isc_source_slice
    import isc_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0,
    parameter int SRV_W    = 4,
    parameter int PRIO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_i,
    input  logic              msg_i,
    input  logic              cfg_we_i,
    input  logic [SRV_W-1:0]  cfg_server_i,
    input  logic [PRIO_W-1:0] cfg_prio_i,
    input  logic [PRIO_W-1:0] cfg_saved_i,
    input  logic              rej_i,
    input  logic              eoi_i,
    input  logic              scan_i,
    input  logic              grant_i,
    output logic              queued_o,
    output logic [SRV_W-1:0]  server_o,
    output logic [PRIO_W-1:0] prio_o
);

    localparam logic [PRIO_W-1:0] MASKED = '1;

    src_stat_t         st_q, st_n;
    logic [SRV_W-1:0]  server_q, server_n;
    logic [PRIO_W-1:0] prio_q, prio_n;
    logic [PRIO_W-1:0] saved_q, saved_n;
    logic              fire;
    logic              lvl_chk;

    // next-state: delivery, notifications, config, input events, walk visit
    always_comb begin
        st_n     = st_q;
        server_n = server_q;
        prio_n   = prio_q;
        saved_n  = saved_q;
        fire     = 1'b0;
        lvl_chk  = 1'b0;

        if (grant_i) begin
            st_n.queued = 1'b0;
        end

        if (rej_i) begin
            if (IS_LEVEL) begin
                st_n.sent = 1'b0;
            end else begin
                st_n.rejected = 1'b1;
            end
        end

        if (eoi_i && IS_LEVEL) begin
            st_n.sent = 1'b0;
        end

        if (cfg_we_i) begin
            server_n = cfg_server_i;
            prio_n   = cfg_prio_i;
            saved_n  = cfg_saved_i;
            if (IS_LEVEL) begin
                lvl_chk = 1'b1;
            end else if (st_n.mpend && (prio_n != MASKED)) begin
                st_n.mpend = 1'b0;
                fire       = 1'b1;
            end
        end

        if (IS_LEVEL && (line_i != st_q.asserted)) begin
            st_n.asserted = line_i;
            lvl_chk       = 1'b1;
        end

        if (!IS_LEVEL && msg_i) begin
            if (prio_n == MASKED) begin
                st_n.mpend = 1'b1;
            end else begin
                fire = 1'b1;
            end
        end

        if (scan_i) begin
            if (IS_LEVEL) begin
                lvl_chk = 1'b1;
            end else if (st_n.rejected) begin
                st_n.rejected = 1'b0;
                if (prio_n != MASKED) begin
                    fire = 1'b1;
                end
            end
        end

        if (lvl_chk && (prio_n != MASKED) && st_n.asserted && !st_n.sent) begin
            st_n.sent = 1'b1;
            fire      = 1'b1;
        end

        if (fire) begin
            st_n.queued = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            server_q <= '0;
            prio_q   <= MASKED;
            saved_q  <= MASKED;
        end else begin
            st_q     <= st_n;
            server_q <= server_n;
            prio_q   <= prio_n;
            saved_q  <= saved_n;
        end
    end

    assign queued_o = st_q.queued;
    assign server_o = server_q;
    assign prio_o   = prio_q;

    p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.queued) |-> (prio_q != MASKED));

    p_level_marks_sent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_LEVEL && $rose(st_q.queued)) |-> st_q.sent);

    p_mpend_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.mpend) |-> st_q.queued);

    p_cfg_saved_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (saved_q == $past(cfg_saved_i)));

endmodule

// File: rtl/isc_pick.sv
module isc_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pending_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] sel_o,
    output logic [N-1:0]     grant_o
);

    logic             lock_q;
    logic [IDX_W-1:0] lock_idx_q;
    logic [IDX_W-1:0] lowest;

    always_comb begin
        lowest = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending_i[i]) begin
                lowest = IDX_W'(i);
            end
        end
    end

    assign valid_o = |pending_i;
    assign sel_o   = lock_q ? lock_idx_q : lowest;

    always_comb begin
        grant_o = '0;
        if (valid_o && ready_i) begin
            grant_o[sel_o] = 1'b1;
        end
    end

    // hold the shown choice across a stall so the payload cannot switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q     <= 1'b0;
            lock_idx_q <= '0;
        end else begin
            lock_q     <= valid_o && !ready_i;
            lock_idx_q <= sel_o;
        end
    end

    p_hold_choice_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && (sel_o == $past(sel_o))));

    p_single_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

endmodule

// File: rtl/isc_scan_fsm.sv
module isc_scan_fsm
    import isc_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         stall_i,
    output logic [N-1:0] hit_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    scan_state_e      state_q, state_n;
    logic [IDX_W-1:0] idx_q, idx_n;

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        unique case (state_q)
            SC_IDLE: begin
                if (start_i) begin
                    state_n = SC_WALK;
                    idx_n   = '0;
                end
            end
            SC_WALK: begin
                if (!stall_i) begin
                    if (idx_q == LAST) begin
                        state_n = SC_IDLE;
                        idx_n   = '0;
                    end else begin
                        idx_n = idx_q + 1'b1;
                    end
                end
            end
            default: state_n = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_n;
            idx_q   <= idx_n;
        end
    end

    always_comb begin
        hit_o = '0;
        unique case (state_q)
            SC_IDLE: hit_o = '0;
            SC_WALK: begin
                if (!stall_i) begin
                    hit_o[idx_q] = 1'b1;
                end
            end
            default: hit_o = '0;
        endcase
    end

    p_walk_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_WALK && !stall_i && idx_q != LAST)
        |=> (state_q == SC_WALK && idx_q == IDX_W'($past(idx_q) + 1'b1)));

    p_walk_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_WALK && stall_i) |=> (state_q == SC_WALK && $stable(idx_q)));

endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl
    import isc_pkg::*;
#(
    parameter int                   NUM_SRC      = 8,
    parameter logic [NUM_SRC-1:0]   SRC_IS_LEVEL = 8'hF0,
    parameter int                   NUM_W        = 8,
    parameter int                   BASE         = 16,
    parameter int                   SRV_W        = 4,
    parameter int                   PRIO_W       = 8,
    localparam int                  IDX_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic [NUM_SRC-1:0] msg_i,
    input  logic               cfg_we_i,
    input  logic [IDX_W-1:0]   cfg_idx_i,
    input  logic [SRV_W-1:0]   cfg_server_i,
    input  logic [PRIO_W-1:0]  cfg_prio_i,
    input  logic [PRIO_W-1:0]  cfg_saved_i,
    input  logic               rej_valid_i,
    input  logic [NUM_W-1:0]   rej_num_i,
    input  logic               eoi_valid_i,
    input  logic [NUM_W-1:0]   eoi_num_i,
    input  logic               replay_i,
    output logic               req_valid_o,
    input  logic               req_ready_i,
    output logic [NUM_W-1:0]   req_num_o,
    output logic [SRV_W-1:0]   req_server_o,
    output logic [PRIO_W-1:0]  req_prio_o
);

    localparam logic [NUM_W:0] LO_NUM = (NUM_W + 1)'(BASE);
    localparam logic [NUM_W:0] HI_NUM = (NUM_W + 1)'(BASE + NUM_SRC);

    logic [NUM_SRC-1:0] queued;
    logic [NUM_SRC-1:0] grant;
    logic [NUM_SRC-1:0] scan_hit;
    logic [NUM_SRC-1:0] rej_hit;
    logic [NUM_SRC-1:0] eoi_hit;
    logic [SRV_W-1:0]   srv_arr  [NUM_SRC];
    logic [PRIO_W-1:0]  prio_arr [NUM_SRC];
    logic [IDX_W-1:0]   sel;
    logic               stall;
    logic               rej_in, eoi_in;
    logic [IDX_W-1:0]   rej_idx, eoi_idx;

    assign rej_in  = ({1'b0, rej_num_i} >= LO_NUM) && ({1'b0, rej_num_i} < HI_NUM);
    assign eoi_in  = ({1'b0, eoi_num_i} >= LO_NUM) && ({1'b0, eoi_num_i} < HI_NUM);
    assign rej_idx = IDX_W'(rej_num_i - NUM_W'(BASE));
    assign eoi_idx = IDX_W'(eoi_num_i - NUM_W'(BASE));

    always_comb begin
        rej_hit = '0;
        eoi_hit = '0;
        if (rej_valid_i && rej_in) rej_hit[rej_idx] = 1'b1;
        if (eoi_valid_i && eoi_in) eoi_hit[eoi_idx] = 1'b1;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            isc_source_slice #(
                .IS_LEVEL (SRC_IS_LEVEL[g]),
                .SRV_W    (SRV_W),
                .PRIO_W   (PRIO_W)
            ) u_slice (
                .clk          (clk),
                .rst_n        (rst_n),
                .line_i       (line_i[g]),
                .msg_i        (msg_i[g]),
                .cfg_we_i     (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
                .cfg_server_i (cfg_server_i),
                .cfg_prio_i   (cfg_prio_i),
                .cfg_saved_i  (cfg_saved_i),
                .rej_i        (rej_hit[g]),
                .eoi_i        (eoi_hit[g]),
                .scan_i       (scan_hit[g]),
                .grant_i      (grant[g]),
                .queued_o     (queued[g]),
                .server_o     (srv_arr[g]),
                .prio_o       (prio_arr[g])
            );
        end
    endgenerate

    isc_pick #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (queued),
        .ready_i   (req_ready_i),
        .valid_o   (req_valid_o),
        .sel_o     (sel),
        .grant_o   (grant)
    );

    assign stall = req_valid_o && !req_ready_i;

    isc_scan_fsm #(
        .N     (NUM_SRC),
        .IDX_W (IDX_W)
    ) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (replay_i),
        .stall_i (stall),
        .hit_o   (scan_hit)
    );

    assign req_num_o    = NUM_W'(BASE) + NUM_W'(sel);
    assign req_server_o = srv_arr[sel];
    assign req_prio_o   = prio_arr[sel];

    p_num_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> (({1'b0, req_num_o} >= LO_NUM) && ({1'b0, req_num_o} < HI_NUM)));

    p_stall_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_num_o)));

endmodule

// File: tb/isc_source_ctrl_bench.sv
`timescale 1ns/1ps
module isc_source_ctrl_bench;

    localparam int N      = 8;
    localparam int NUM_W  = 8;
    localparam int BASE   = 16;
    localparam int SRV_W  = 4;
    localparam int PRIO_W = 8;
    localparam int IDX_W  = 3;

    typedef struct packed {
        logic [NUM_W-1:0]  num;
        logic [SRV_W-1:0]  srv;
        logic [PRIO_W-1:0] prio;
    } item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N-1:0]       line_i = '0;
    logic [N-1:0]       msg_i = '0;
    logic               cfg_we_i = 1'b0;
    logic [IDX_W-1:0]   cfg_idx_i = '0;
    logic [SRV_W-1:0]   cfg_server_i = '0;
    logic [PRIO_W-1:0]  cfg_prio_i = '0;
    logic [PRIO_W-1:0]  cfg_saved_i = '0;
    logic               rej_valid_i = 1'b0;
    logic [NUM_W-1:0]   rej_num_i = '0;
    logic               eoi_valid_i = 1'b0;
    logic [NUM_W-1:0]   eoi_num_i = '0;
    logic               replay_i = 1'b0;
    logic               req_valid_o;
    logic               req_ready_i = 1'b1;
    logic [NUM_W-1:0]   req_num_o;
    logic [SRV_W-1:0]   req_server_o;
    logic [PRIO_W-1:0]  req_prio_o;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 1'b0;
    item_t exp_q[$];
    string cur_tag = "R1";

    always #4 clk = ~clk;

    isc_source_ctrl #(
        .NUM_SRC(N), .SRC_IS_LEVEL(8'hF0), .NUM_W(NUM_W), .BASE(BASE),
        .SRV_W(SRV_W), .PRIO_W(PRIO_W)
    ) u_isc_source_ctrl (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .msg_i(msg_i),
        .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i), .cfg_server_i(cfg_server_i),
        .cfg_prio_i(cfg_prio_i), .cfg_saved_i(cfg_saved_i),
        .rej_valid_i(rej_valid_i), .rej_num_i(rej_num_i),
        .eoi_valid_i(eoi_valid_i), .eoi_num_i(eoi_num_i), .replay_i(replay_i),
        .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_num_o(req_num_o),
        .req_server_o(req_server_o), .req_prio_o(req_prio_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: compare every handshake against the scoreboard
    always @(negedge clk) begin
        if (rst_n && req_valid_o && req_ready_i) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {cur_tag, " unexpected request"}, int'(req_num_o), 0);
            end else begin
                item_t e;
                e = exp_q.pop_front();
                check(req_num_o == e.num && req_server_o == e.srv && req_prio_o == e.prio,
                      {cur_tag, " request"},
                      int'({req_num_o, req_server_o, req_prio_o}), int'(e));
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_req(input int idx, input int srv, input int prio);
        item_t e;
        e.num = NUM_W'(BASE + idx);
        e.srv = SRV_W'(srv);
        e.prio = PRIO_W'(prio);
        exp_q.push_back(e);
    endtask

    task automatic cfg(input int idx, input int srv, input int prio);
        cfg_we_i = 1'b1; cfg_idx_i = IDX_W'(idx);
        cfg_server_i = SRV_W'(srv); cfg_prio_i = PRIO_W'(prio); cfg_saved_i = PRIO_W'(prio ^ 1);
        tick(1);
        cfg_we_i = 1'b0;
    endtask

    task automatic pulse(input int idx);
        msg_i[idx] = 1'b1; tick(1); msg_i[idx] = 1'b0;
    endtask

    task automatic reject(input int num);
        rej_valid_i = 1'b1; rej_num_i = NUM_W'(num); tick(1); rej_valid_i = 1'b0;
    endtask

    task automatic eoi(input int num);
        eoi_valid_i = 1'b1; eoi_num_i = NUM_W'(num); tick(1); eoi_valid_i = 1'b0;
    endtask

    task automatic replay();
        replay_i = 1'b1; tick(1); replay_i = 1'b0;
    endtask

    task automatic drain(input string tag);
        for (int k = 0; k < 40 && exp_q.size() != 0; k++) tick(1);
        tick(2);
        check(exp_q.size() == 0, {tag, " all expected requests seen"}, exp_q.size(), 0);
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            if (req_valid_o) seen = 1'b1;
            tick(1);
        end
        check(!seen, {tag, " no request"}, int'(seen), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: quiet after reset
        cur_tag = "R1";
        check(req_valid_o == 1'b0, "R1 reset valid", int'(req_valid_o), 0);

        // R3: masked pulse, then R4 unmask releases it
        cur_tag = "R3";
        pulse(0);
        quiet(4, "R3 masked message");
        cur_tag = "R4";
        expect_req(0, 3, 5);
        cfg(0, 3, 5);
        drain("R4 unmask pending");
        cfg(1, 2, 4);
        quiet(3, "R4 no pending no request");

        // R3 and R2: unmasked pulse, number BASE+1
        cur_tag = "R3";
        expect_req(1, 2, 4);
        pulse(1);
        tick(1);
        check(exp_q.size() == 0, "R3 request one cycle after pulse", exp_q.size(), 0);
        drain("R2 number base plus index");

        // R6 + R8: reject message, replay once, second replay silent
        cur_tag = "R6";
        reject(BASE + 1);
        quiet(3, "R6 reject raises nothing");
        cur_tag = "R8";
        expect_req(1, 2, 4);
        replay();
        drain("R8 rejected message replayed");
        replay();
        quiet(12, "R8 replay without rejection");

        // R5: level source
        cur_tag = "R5";
        cfg(4, 1, 6);
        expect_req(4, 1, 6);
        line_i[4] = 1'b1;
        drain("R5 rising line");
        quiet(5, "R5 held line single request");
        cur_tag = "R7";
        eoi(BASE + 4);
        quiet(3, "R7 eoi alone");
        expect_req(4, 1, 6);
        replay();
        drain("R7 eoi clears sent");
        cur_tag = "R6";
        reject(BASE + 4);
        expect_req(4, 1, 6);
        replay();
        drain("R6 level reject clears sent");
        line_i[4] = 1'b0;
        eoi(BASE + 4);
        replay();
        quiet(12, "R5 low line no replay");

        // R10: out of range numbers; R7: eoi on message no effect
        cur_tag = "R10";
        reject(BASE + N);
        reject(BASE - 1);
        replay();
        quiet(12, "R10 out of range reject");
        eoi(BASE + N + 4);
        cur_tag = "R7";
        eoi(BASE + 0);
        replay();
        quiet(12, "R7 eoi on message");

        // R9: simultaneous level rises during stall
        cur_tag = "R9";
        cfg(5, 7, 2);
        cfg(6, 9, 1);
        req_ready_i = 1'b0;
        line_i[5] = 1'b1;
        line_i[6] = 1'b1;
        tick(1);
        begin
            logic [NUM_W-1:0] held;
            held = req_num_o;
            tick(4);
            check(req_valid_o && req_num_o == held && held == NUM_W'(BASE + 5),
                  "R9 held lowest during stall", int'(req_num_o), BASE + 5);
        end
        expect_req(5, 7, 2);
        expect_req(6, 9, 1);
        req_ready_i = 1'b1;
        drain("R9 lowest index first");

        // R8/R9: walk stalls mid-way
        cur_tag = "R8";
        reject(BASE + 0);
        reject(BASE + 1);
        req_ready_i = 1'b0;
        replay();
        tick(6);
        check(req_valid_o && req_num_o == NUM_W'(BASE), "R9 walk frozen on stall",
              int'(req_num_o), BASE);
        expect_req(0, 3, 5);
        expect_req(1, 2, 4);
        req_ready_i = 1'b1;
        drain("R8 stalled walk order");

        // R1: reset keeps kinds, masks all
        cur_tag = "R1";
        line_i = '0;
        tick(1);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check(req_valid_o == 1'b0, "R1 valid after second reset", int'(req_valid_o), 0);
        pulse(1);
        quiet(3, "R1 priority masked after reset");
        cfg(4, 2, 3);
        expect_req(4, 2, 3);
        line_i[4] = 1'b1;
        drain("R1 level kind kept");
        line_i[4] = 1'b0;
        tick(2);

        finish_run();
    end

endmodule